// File: doc/BRIEF.md
# Beacon Timer Spacing Monitor

This block watches three of the periodic beacon timers of a wireless MAC and reports whether the gaps between them still match their programmed values. Each timer advances by one beacon interval when the local time reaches it. A jump of the local time can move past one timer and leave it un-advanced while its neighbour keeps moving. After that, the gap between the two timers is wrong and stays wrong until the time counter wraps.

Two pairs are checked. The first is the next-beacon timer and the end of the announcement window, which must follow it by exactly one time unit. The second is the DMA alert timer and the next-beacon timer. The DMA alert timer is held in eighths of a time unit and is scaled down before the comparison. It must precede the next-beacon timer by a programmable response margin.

A pair is accepted in any of four relations. The acceptance covers the moment when only one timer of the pair has advanced, and the moment when either timer has wrapped around its width. Without this, those moments would raise false alarms. The result is registered as an OK flag. A sticky error bit records any cycle in which the flag was low, and software clears it with a one-cycle pulse.

Top module: `beacon_spacing_mon`

## Requirements
- R1: A pair (first A, second B, gap W, interval I) is accepted when B - A = W, with all values taken as unsigned integers.
- R2: A pair is accepted when A - B = I - W, which is the case where A has advanced and B has not yet.
- R3: A pair is accepted when (A + 2^TW) - B = I - W, which is the case where A has advanced and wrapped.
- R4: A pair is accepted when (B + 2^TW) - A = W, which is the case where B has wrapped. A pair that meets none of R1 to R4 is rejected.
- R5: The announcement pair uses A = next-beacon timer, B = window-end timer and W = 1.
- R6: The DMA pair uses A = DMA alert timer shifted right by FRAC bits (FRAC = 3), B = next-beacon timer and W = the margin input. The low FRAC bits of the DMA alert timer have no effect.
- R7: `win_ok` is the AND of both pair results. It appears on the clock edge after the inputs are presented.
- R8: `err_sticky` goes to 1 on the edge after any cycle in which `win_ok` is 0, and it then holds.
- R9: A 1 on `err_clr` clears `err_sticky` on the next edge only if `win_ok` is 1 in that cycle. While `win_ok` is 0, the clear has no effect.
- R10: After reset, `win_ok` is 1 and `err_sticky` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nbtt_tu | input | TW | Next-beacon timer, in time units |
| win_end_tu | input | TW | Announcement-window end timer, in time units |
| dma_alert | input | TW+FRAC | DMA alert timer, in 1/2^FRAC time units |
| bcn_intval | input | TW | Beacon interval, in time units |
| dma_margin | input | TW | DMA response margin, in time units |
| err_clr | input | 1 | Clear pulse for the sticky error |
| win_ok | output | 1 | Registered result that both pairs are accepted |
| err_sticky | output | 1 | Sticky record of any cycle with `win_ok` low |

## Verification
The bench builds the block with its default TW = 16 and FRAC = 3, so the wrap relations sit at the real 65536 boundary. This lets directed values such as 65535 to 0 and 40 against 65500 exercise R3 and R4 exactly. With FRAC = 3, non-zero fraction bits on the DMA timer show that those bits are discarded. A walk of near-valid timer triples, drawn around both wrap points with interval and margin varied, is compared every cycle against an integer model of the four relations.

// File: rtl/beacon_spacing_pkg.sv
package beacon_spacing_pkg;
   localparam int unsigned DEF_TW   = 16;
   localparam int unsigned DEF_FRAC = 3;
   localparam int unsigned DEF_GAP  = 1;
   localparam int unsigned GUARD    = 3;

   typedef struct packed {
      logic atim_ok;
      logic dma_ok;
   } pair_res_t;
endpackage

// File: rtl/tu_pair_match.sv
module tu_pair_match #(
   parameter int unsigned TW = 16
) (
   input  logic [TW-1:0] a_tu,
   input  logic [TW-1:0] b_tu,
   input  logic [TW-1:0] gap_tu,
   input  logic [TW-1:0] intval_tu,
   output logic          accept
);
   import beacon_spacing_pkg::*;
   localparam int unsigned XW = TW + GUARD;
   localparam logic signed [XW-1:0] SPAN = {{(GUARD-1){1'b0}}, 1'b1, {TW{1'b0}}};

   generate
      if (TW < 4) begin : g_bad_width
         $error("tu_pair_match: TW must be at least 4");
      end
   endgenerate

   logic signed [XW-1:0] sa, sb, sg, si, rem;
   logic                 rel_direct, rel_a_ahead, rel_a_wrap, rel_b_wrap;

   always_comb begin
      sa  = $signed({{GUARD{1'b0}}, a_tu});
      sb  = $signed({{GUARD{1'b0}}, b_tu});
      sg  = $signed({{GUARD{1'b0}}, gap_tu});
      si  = $signed({{GUARD{1'b0}}, intval_tu});
      rem = si - sg;
      rel_direct  = (sb - sa) == sg;
      rel_a_ahead = (sa - sb) == rem;
      rel_a_wrap  = (sa + SPAN - sb) == rem;
      rel_b_wrap  = (sb + SPAN - sa) == sg;
      accept = rel_direct | rel_a_ahead | rel_a_wrap | rel_b_wrap;
   end

   always_comb begin
      if ({1'b0, b_tu} == {1'b0, a_tu} + {1'b0, gap_tu})
         assert_direct_R1: assert (accept);
      if ({1'b0, a_tu} + {1'b0, gap_tu} == {1'b0, b_tu} + {1'b0, intval_tu})
         assert_a_ahead_R2: assert (accept);
      if ({1'b1, a_tu} + {1'b0, gap_tu} == {1'b0, b_tu} + {1'b0, intval_tu})
         assert_a_wrap_R3: assert (accept);
      if ({1'b1, b_tu} == {1'b0, a_tu} + {1'b0, gap_tu})
         assert_b_wrap_R4: assert (accept);
   end
endmodule

// File: rtl/dma_tu_scale.sv
module dma_tu_scale #(
   parameter int unsigned TW   = 16,
   parameter int unsigned FRAC = 3
) (
   input  logic [TW+FRAC-1:0] fine_in,
   output logic [TW-1:0]      tu_out
);
   generate
      if (FRAC == 0) begin : g_whole
         assign tu_out = fine_in[TW-1:0];
      end else begin : g_frac
         logic unused_frac;
         assign unused_frac = ^fine_in[FRAC-1:0];
         assign tu_out = fine_in[FRAC +: TW];
      end
   endgenerate
endmodule

// File: rtl/beacon_spacing_mon.sv
module beacon_spacing_mon #(
   parameter int unsigned TW   = beacon_spacing_pkg::DEF_TW,
   parameter int unsigned FRAC = beacon_spacing_pkg::DEF_FRAC,
   parameter int unsigned GAP  = beacon_spacing_pkg::DEF_GAP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TW-1:0]      nbtt_tu,
   input  logic [TW-1:0]      win_end_tu,
   input  logic [TW+FRAC-1:0] dma_alert,
   input  logic [TW-1:0]      bcn_intval,
   input  logic [TW-1:0]      dma_margin,
   input  logic               err_clr,
   output logic               win_ok,
   output logic               err_sticky
);
   import beacon_spacing_pkg::*;
   localparam logic [TW-1:0] GAP_TU = TW'(GAP);

   generate
      if (FRAC > 8) begin : g_bad_frac
         $error("beacon_spacing_mon: FRAC above 8 is not supported");
      end
      if (GAP >= (1 << TW)) begin : g_bad_gap
         $error("beacon_spacing_mon: GAP does not fit in TW bits");
      end
   endgenerate

   logic [TW-1:0] dma_tu;
   pair_res_t     res;

   dma_tu_scale #(.TW(TW), .FRAC(FRAC)) u_scale (
      .fine_in (dma_alert),
      .tu_out  (dma_tu)
   );

   tu_pair_match #(.TW(TW)) u_atim_pair (
      .a_tu      (nbtt_tu),
      .b_tu      (win_end_tu),
      .gap_tu    (GAP_TU),
      .intval_tu (bcn_intval),
      .accept    (res.atim_ok)
   );

   tu_pair_match #(.TW(TW)) u_dma_pair (
      .a_tu      (dma_tu),
      .b_tu      (nbtt_tu),
      .gap_tu    (dma_margin),
      .intval_tu (bcn_intval),
      .accept    (res.dma_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_ok     <= 1'b1;
         err_sticky <= 1'b0;
      end else begin
         win_ok     <= res.atim_ok & res.dma_ok;
         err_sticky <= (err_sticky & ~err_clr) | ~win_ok;
      end
   end

   assert_err_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !win_ok |=> err_sticky);
   assert_err_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !err_clr) |=> err_sticky);
   assert_clr_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !win_ok) |=> err_sticky);
   assert_clr_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && win_ok) |=> !err_sticky);
endmodule

// File: tb/beacon_spacing_mon_tb.sv
`timescale 1ns/1ps
module beacon_spacing_mon_tb_top;
   localparam int TW   = 16;
   localparam int FRAC = 3;
   localparam int SPAN = 1 << TW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TW-1:0] nbtt_tu = '0, win_end_tu = 16'd1, bcn_intval = 16'd100, dma_margin = '0;
   logic [TW+FRAC-1:0] dma_alert = '0;
   logic err_clr = 1'b0;
   logic win_ok, err_sticky;

   int checks = 0, failures = 0;
   bit m_ok = 1'b1, m_err = 1'b0;

   always #2.5 clk = ~clk;

   beacon_spacing_mon dut_i (
      .clk(clk), .rst_n(rst_n), .nbtt_tu(nbtt_tu), .win_end_tu(win_end_tu),
      .dma_alert(dma_alert), .bcn_intval(bcn_intval), .dma_margin(dma_margin),
      .err_clr(err_clr), .win_ok(win_ok), .err_sticky(err_sticky)
   );

   function automatic bit rel_ok(int a, int b, int w, int iv);
      return (b - a == w) || (a - b == iv - w) ||
             (a + SPAN - b == iv - w) || (b + SPAN - a == w);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ok = 1'b1; m_err = 1'b0;
      end else begin
         m_err = (m_err && !err_clr) || !m_ok;
         m_ok  = rel_ok(int'(nbtt_tu), int'(win_end_tu), 1, int'(bcn_intval)) &&
                 rel_ok(int'(dma_alert >> FRAC), int'(nbtt_tu), int'(dma_margin), int'(bcn_intval));
      end
   end

   task automatic check(input string tag);
      checks++;
      if (win_ok !== m_ok || err_sticky !== m_err) begin
         failures++;
         $display("FAIL %s: ok=%b err=%b expected ok=%b err=%b", tag, win_ok, err_sticky, m_ok, m_err);
      end
   endtask

   task automatic apply(input int n, input int e, input int d, input int iv,
                        input int mg, input bit clr, input string tag);
      @(negedge clk);
      nbtt_tu = TW'(n); win_end_tu = TW'(e); dma_alert = (TW+FRAC)'(d);
      bcn_intval = TW'(iv); dma_margin = TW'(mg); err_clr = clr;
      @(posedge clk); #1;
      check(tag);
   endtask

   task automatic expect_vals(input bit ok, input bit err, input string tag);
      checks++;
      if (win_ok !== ok || err_sticky !== err) begin
         failures++;
         $display("FAIL %s: ok=%b err=%b expected ok=%b err=%b", tag, win_ok, err_sticky, ok, err);
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog: ok=%b err=%b expected run end", win_ok, err_sticky);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; expect_vals(1'b1, 1'b0, "R10 reset");
      @(negedge clk); rst_n = 1'b1;
      // R1 and R5: direct, announcement gap 1; R6 DMA 998 precedes 1000 by 2
      apply(1000, 1001, 998 * 8, 100, 2, 0, "R1");
      apply(1000, 1001, 998 * 8, 100, 2, 0, "R5");
      expect_vals(1'b1, 1'b0, "R7 ok both");
      // R6: fraction bits ignored
      apply(1000, 1001, 998 * 8 + 7, 100, 2, 0, "R6 frac");
      expect_vals(1'b1, 1'b0, "R6 frac ok");
      // R2: nbtt advanced, window end not yet (1100 - 1001 = 99)
      apply(1100, 1001, 1098 * 8, 100, 2, 0, "R2");
      expect_vals(1'b1, 1'b0, "R2 ok");
      // R3: nbtt advanced and wrapped, interval 77
      apply(40, 65500, 38 * 8, 77, 2, 0, "R3");
      expect_vals(1'b1, 1'b0, "R3 ok");
      // R4: window end wrapped
      apply(65535, 0, 65533 * 8, 100, 2, 0, "R4");
      expect_vals(1'b1, 1'b0, "R4 ok");
      // R6: DMA pair wrap, 65535 precedes 1 by 2
      apply(1, 2, 65535 * 8, 100, 2, 0, "R6 wrap");
      expect_vals(1'b1, 1'b0, "R6 wrap ok");
      // R7: bad gap drops ok one edge later, R8 sets sticky on the next
      apply(1000, 1003, 998 * 8, 100, 2, 0, "R7 bad");
      expect_vals(1'b0, 1'b0, "R7 low");
      apply(1000, 1003, 998 * 8, 100, 2, 0, "R8");
      expect_vals(1'b0, 1'b1, "R8 set");
      // R9: clear while ok is low has no effect
      apply(1000, 1003, 998 * 8, 100, 2, 1, "R9 blocked");
      expect_vals(1'b0, 1'b1, "R9 blocked");
      // R6: bad DMA margin alone drops ok
      apply(1000, 1001, 997 * 8, 100, 2, 0, "R6 bad");
      expect_vals(1'b0, 1'b1, "R6 bad low");
      apply(1000, 1001, 998 * 8, 100, 2, 0, "R8 hold");
      expect_vals(1'b1, 1'b1, "R8 hold");
      apply(1000, 1001, 998 * 8, 100, 2, 1, "R9 clear");
      expect_vals(1'b1, 1'b0, "R9 cleared");
      // mixed walk near wrap points
      for (int k = 0; k < 400; k++) begin
         int base, iv, mg, n, e, d;
         base = (k % 2 == 0) ? (65536 - 8 + int'($urandom_range(0, 15))) % 65536
                             : int'($urandom_range(0, 65535));
         iv = int'($urandom_range(5, 120));
         mg = int'($urandom_range(0, 4));
         n = base;
         case ($urandom_range(0, 3))
            0: e = (n + 1) % 65536;
            1: e = (n - iv + 1 + 65536) % 65536;
            2: e = (n + int'($urandom_range(0, 3))) % 65536;
            default: e = int'($urandom_range(0, 65535));
         endcase
         d = (((n - mg - ($urandom_range(0, 3) == 0 ? 1 : 0)) + 65536) % 65536) * 8
             + int'($urandom_range(0, 7));
         apply(n, e, d, iv, mg, ($urandom_range(0, 7) == 0), "R7 walk");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule